// File: doc/BRIEF.md
# Software Write-Protect Command Sequencer

This block sits between the decoded host write events of a byte-wide flash-style memory and its page-load controller. Every host write arrives as one cycle of `wr_valid` with an address and a data byte. The sequencer watches these events for fixed multi-write command patterns. It keeps a protect flag that survives the ordinary reset, and for each write it decides one of three outcomes: forward the byte to the page buffer, start a dummy write cycle, or consume the byte as part of a command.

While the protect flag is clear, ordinary writes pass straight through. A three-write pattern sets the flag: AA to 5555h, then 55 to 2AAAh, then A0 to 5555h. The same pattern must open every later page load while the flag is set. Writes that follow the pattern are forwarded until the load window closes. The window closes when no write arrives for more than `WIN_CYC` cycles. A protected write that was not preceded by the pattern stores nothing. It pulses `dummy_start`, so the downstream controller runs its write timer and status polling as if a program had happened. A six-write pattern clears the flag: AA/5555, 55/2AAA, 80/5555, AA/5555, 55/2AAA, 20/5555. A separate power-on-default input (`por_clr`) returns the flag to its unprotected default.

Top module: `wp_cmd_seq`

## Requirements
- R1: After `por_clr` has been asserted, `prot_on` is 0, and `ld_en` and `dummy_start` are 0 while no write is presented.
- R2: While `prot_on` is 0, an ordinary write taken at clock edge k produces `ld_en`=1 with the same `ld_addr`/`ld_data` after edge k, for one cycle, and `dummy_start` stays 0.
- R3: The writes AA/5555h, 55/2AAAh, A0/5555h on consecutive write events (each within the load window) set `prot_on` to 1 after the third one. No write of a recognised command step is forwarded or produces `dummy_start`.
- R4: While `prot_on` is 1, an ordinary write that is not inside an unlocked load window produces `dummy_start`=1 for one cycle and no `ld_en`. `prot_on` stays 1.
- R5: While `prot_on` is 1, ordinary writes that follow the three-write pattern are forwarded as in R2 until the load window closes. The first ordinary write after the window closes is handled as in R4.
- R6: The six-write pattern AA/5555h, 55/2AAAh, 80/5555h, AA/5555h, 55/2AAAh, 20/5555h clears `prot_on` after the sixth write. `prot_on` is still 1 after the fifth. Later writes are forwarded as in R2.
- R7: A write that does not match the next expected step of a pattern in progress abandons the pattern. That write is handled as an ordinary write (R2 or R4), and recognition starts again from the first step. Writes of a matching prefix are consumed and never forwarded.
- R8: The load window stays open while consecutive writes are at most `WIN_CYC` clock edges apart. A gap of `WIN_CYC`+1 edges or more closes it, which abandons any partial pattern and ends the unlocked state.
- R9: `rst` clears pattern progress, the window and the outputs `ld_en`/`dummy_start`, but leaves `prot_on` unchanged. Only `por_clr` clears `prot_on` outside the disable pattern.
- R10: `ld_en` and `dummy_start` are registered and never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; does not touch the protect flag |
| por_clr | input | 1 | Synchronous power-on-default; clears the protect flag and pattern progress |
| wr_valid | input | 1 | One-cycle host write event |
| wr_addr | input | ADDR_W | Write address (at least 15 bits) |
| wr_data | input | DATA_W | Write data byte |
| ld_en | output | 1 | Forward pulse to the page buffer |
| ld_addr | output | ADDR_W | Address of the forwarded write |
| ld_data | output | DATA_W | Data of the forwarded write |
| dummy_start | output | 1 | Pulse that starts a write cycle which stores nothing |
| prot_on | output | 1 | Protect flag |

## Verification
A wrong pattern step or unlocked flag does not show at the ports until the next write. It then appears one cycle after that write as a forward where a dummy pulse was due, or the other way round, or as a command byte leaking out on `ld_en`. A wrong protect flag is visible on `prot_on` in the cycle after the write that completes a pattern. The bench therefore checks every write's outcome one cycle later. It places writes exactly `WIN_CYC` and `WIN_CYC`+1 edges apart so that an off-by-one in the window counter changes a forward into a dummy cycle.

// File: rtl/wp_cmd_pkg.sv
package wp_cmd_pkg;
  localparam int SEQ_STEPS = 6;

  localparam logic [15:0] CMD_ADDR_A = 16'h5555;
  localparam logic [15:0] CMD_ADDR_B = 16'h2AAA;

  localparam logic [7:0] CODE_LEAD   = 8'hAA;
  localparam logic [7:0] CODE_FOLLOW = 8'h55;
  localparam logic [7:0] CODE_UNLOCK = 8'hA0;
  localparam logic [7:0] CODE_BRANCH = 8'h80;
  localparam logic [7:0] CODE_CLEAR  = 8'h20;

  // Number of pattern writes already matched.
  typedef enum logic [2:0] {
    SQ_0 = 3'd0,
    SQ_1 = 3'd1,
    SQ_2 = 3'd2,
    SQ_3 = 3'd3,
    SQ_4 = 3'd4,
    SQ_5 = 3'd5
  } seq_t;

  // Address expected at step idx of the long (clear) pattern.
  function automatic logic [15:0] step_addr(input int idx);
    return (idx == 1 || idx == 4) ? CMD_ADDR_B : CMD_ADDR_A;
  endfunction

  // Data expected at step idx of the long (clear) pattern.
  function automatic logic [7:0] step_data(input int idx);
    case (idx)
      0, 3:    return CODE_LEAD;
      1, 4:    return CODE_FOLLOW;
      2:       return CODE_BRANCH;
      default: return CODE_CLEAR;
    endcase
  endfunction
endpackage

// File: rtl/wp_load_window.sv
module wp_load_window #(
  parameter int WIN_CYC = 37500
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_valid,
  output logic win_open,
  output logic win_expire
);
  localparam int CNT_W = $clog2(WIN_CYC + 1);

  logic [CNT_W-1:0] gap_cnt;
  logic             active;

  assign win_expire = active && !wr_valid && (gap_cnt == CNT_W'(WIN_CYC - 1));
  assign win_open   = active;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      gap_cnt <= '0;
    end else if (wr_valid) begin
      active  <= 1'b1;
      gap_cnt <= '0;
    end else if (win_expire) begin
      active  <= 1'b0;
      gap_cnt <= '0;
    end else if (active) begin
      gap_cnt <= gap_cnt + 1'b1;
    end
  end

  // R8: an idle window has its gap counter parked at zero
  assert_idle_cnt_R8: assert property (@(posedge clk) disable iff (rst)
    !active |-> (gap_cnt == '0));
endmodule

// File: rtl/wp_cmd_match.sv
module wp_cmd_match
  import wp_cmd_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    data,
  output logic [SEQ_STEPS-1:0] step_hit,
  output logic                 unlock_hit
);
  for (genvar i = 0; i < SEQ_STEPS; i++) begin : g_step
    assign step_hit[i] = (addr == ADDR_W'(step_addr(i))) &&
                         (data == DATA_W'(step_data(i)));
  end

  assign unlock_hit = (addr == ADDR_W'(CMD_ADDR_A)) &&
                      (data == DATA_W'(CODE_UNLOCK));
endmodule

// File: rtl/wp_seq_ctrl.sv
module wp_seq_ctrl
  import wp_cmd_pkg::*;
(
  input  logic                 clk,
  input  logic                 clr,
  input  logic                 wr_valid,
  input  logic [SEQ_STEPS-1:0] step_hit,
  input  logic                 unlock_hit,
  input  logic                 win_expire,
  input  logic                 win_open,
  input  logic                 prot_on,
  output logic                 set_prot,
  output logic                 clear_prot,
  output logic                 fwd_ev,
  output logic                 dummy_ev,
  output logic                 unlocked
);
  seq_t state, state_n;
  logic unlocked_n;
  logic cur_hit;
  logic ordinary;
  logic act;

  assign act = wr_valid && !clr;

  always_comb begin
    case (state)
      SQ_0:    cur_hit = step_hit[0];
      SQ_1:    cur_hit = step_hit[1];
      SQ_2:    cur_hit = step_hit[2];
      SQ_3:    cur_hit = step_hit[3];
      SQ_4:    cur_hit = step_hit[4];
      SQ_5:    cur_hit = step_hit[5];
      default: cur_hit = 1'b0;
    endcase
  end

  always_comb begin
    state_n    = state;
    unlocked_n = unlocked;
    set_prot   = 1'b0;
    clear_prot = 1'b0;
    ordinary   = 1'b0;
    if (act) begin
      if (state == SQ_2 && unlock_hit) begin
        state_n    = SQ_0;
        set_prot   = 1'b1;
        unlocked_n = 1'b1;
      end else if (cur_hit) begin
        case (state)
          SQ_0:    state_n = SQ_1;
          SQ_1:    state_n = SQ_2;
          SQ_2:    state_n = SQ_3;
          SQ_3:    state_n = SQ_4;
          SQ_4:    state_n = SQ_5;
          default: begin
            state_n    = SQ_0;
            clear_prot = 1'b1;
            unlocked_n = 1'b0;
          end
        endcase
      end else begin
        state_n  = SQ_0;
        ordinary = 1'b1;
      end
    end else if (win_expire) begin
      state_n    = SQ_0;
      unlocked_n = 1'b0;
    end
  end

  assign fwd_ev   = ordinary && (!prot_on || unlocked);
  assign dummy_ev = ordinary && prot_on && !unlocked;

  always_ff @(posedge clk) begin
    if (clr) begin
      state    <= SQ_0;
      unlocked <= 1'b0;
    end else begin
      state    <= state_n;
      unlocked <= unlocked_n;
    end
  end

  // R8: a partly matched pattern only exists inside an open load window
  assert_seq_in_window_R8: assert property (@(posedge clk) disable iff (clr)
    (state != SQ_0) |-> win_open);

  // R5: the unlocked state only exists while protection is set
  assert_unlock_needs_prot_R5: assert property (@(posedge clk) disable iff (clr)
    unlocked |-> prot_on);
endmodule

// File: rtl/wp_lock_bit.sv
module wp_lock_bit (
  input  logic clk,
  input  logic por_clr,
  input  logic set_prot,
  input  logic clear_prot,
  output logic prot_on
);
  // Deliberately outside the ordinary reset: only the power-on default clears it.
  always_ff @(posedge clk) begin
    if (por_clr)         prot_on <= 1'b0;
    else if (set_prot)   prot_on <= 1'b1;
    else if (clear_prot) prot_on <= 1'b0;
  end
endmodule

// File: rtl/wp_cmd_seq.sv
module wp_cmd_seq
  import wp_cmd_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int DATA_W  = 8,
  parameter int WIN_CYC = 37500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por_clr,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              ld_en,
  output logic [ADDR_W-1:0] ld_addr,
  output logic [DATA_W-1:0] ld_data,
  output logic              dummy_start,
  output logic              prot_on
);
  logic [SEQ_STEPS-1:0] step_hit;
  logic unlock_hit;
  logic win_open, win_expire;
  logic set_prot, clear_prot;
  logic fwd_ev, dummy_ev;
  logic unlocked;
  logic seq_clr;

  assign seq_clr = rst || por_clr;

  wp_load_window #(.WIN_CYC(WIN_CYC)) u_window (
    .clk        (clk),
    .rst        (rst),
    .wr_valid   (wr_valid),
    .win_open   (win_open),
    .win_expire (win_expire)
  );

  wp_cmd_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
    .addr       (wr_addr),
    .data       (wr_data),
    .step_hit   (step_hit),
    .unlock_hit (unlock_hit)
  );

  wp_seq_ctrl u_ctrl (
    .clk        (clk),
    .clr        (seq_clr),
    .wr_valid   (wr_valid),
    .step_hit   (step_hit),
    .unlock_hit (unlock_hit),
    .win_expire (win_expire),
    .win_open   (win_open),
    .prot_on    (prot_on),
    .set_prot   (set_prot),
    .clear_prot (clear_prot),
    .fwd_ev     (fwd_ev),
    .dummy_ev   (dummy_ev),
    .unlocked   (unlocked)
  );

  wp_lock_bit u_lock (
    .clk        (clk),
    .por_clr    (por_clr),
    .set_prot   (set_prot),
    .clear_prot (clear_prot),
    .prot_on    (prot_on)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_en       <= 1'b0;
      dummy_start <= 1'b0;
      ld_addr     <= '0;
      ld_data     <= '0;
    end else begin
      ld_en       <= fwd_ev;
      dummy_start <= dummy_ev;
      if (fwd_ev) begin
        ld_addr <= wr_addr;
        ld_data <= wr_data;
      end
    end
  end

  // R10: forward and dummy pulses are exclusive
  assert_excl_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ld_en, dummy_start}));

  // R4: a dummy cycle is only started under protection
  assert_dummy_needs_prot_R4: assert property (@(posedge clk) disable iff (rst || por_clr)
    dummy_start |-> prot_on);

  // R3: the write that sets protection is consumed
  assert_enable_consumed_R3: assert property (@(posedge clk) disable iff (rst || por_clr)
    $rose(prot_on) |-> (!ld_en && !dummy_start));

  // R6: the write that clears protection is consumed
  assert_disable_consumed_R6: assert property (@(posedge clk) disable iff (rst || por_clr)
    $fell(prot_on) |-> (!ld_en && !dummy_start));

  // R9: the ordinary reset leaves the protect flag alone
  assert_reset_keeps_prot_R9: assert property (@(posedge clk) disable iff (por_clr)
    rst |=> (prot_on == $past(prot_on)));
endmodule

// File: tb/wp_cmd_seq_bench.sv
`timescale 1ns/1ps
module wp_cmd_seq_bench;
  localparam int W = 8;

  logic        clk = 1'b0;
  logic        rst, por_clr, wr_valid;
  logic [14:0] wr_addr;
  logic [7:0]  wr_data;
  logic        ld_en, dummy_start, prot_on;
  logic [14:0] ld_addr;
  logic [7:0]  ld_data;

  int n_checks = 0;
  int n_bad    = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  wp_cmd_seq #(.ADDR_W(15), .DATA_W(8), .WIN_CYC(W)) u_wp_cmd_seq (
    .clk(clk), .rst(rst), .por_clr(por_clr),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .dummy_start(dummy_start), .prot_on(prot_on)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_out(input string req, input logic e_ld,
                           input logic e_dm, input logic e_prot);
    check(req, "ld_en", 32'(ld_en), 32'(e_ld));
    check(req, "dummy_start", 32'(dummy_start), 32'(e_dm));
    check(req, "prot_on", 32'(prot_on), 32'(e_prot));
    check("R10", "pulse overlap", 32'(ld_en & dummy_start), 32'd0);
  endtask

  task automatic check_fwd(input string req, input logic [14:0] a, input logic [7:0] d);
    check(req, "ld_addr", 32'(ld_addr), 32'(a));
    check(req, "ld_data", 32'(ld_data), 32'(d));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drive one write event; returns at the negedge after it was taken.
  task automatic do_write(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic seq_unlock(input string req);
    do_write(15'h5555, 8'hAA); check_out(req, 0, 0, prot_on);
    do_write(15'h2AAA, 8'h55); check_out(req, 0, 0, prot_on);
    do_write(15'h5555, 8'hA0); check_out(req, 0, 0, 1);
  endtask

  task automatic t_reset_state;
    check_out("R1", 0, 0, 0);
  endtask

  task automatic t_plain_write;
    idle(W);
    do_write(15'h1234, 8'h5A);
    check_out("R2", 1, 0, 0);
    check_fwd("R2", 15'h1234, 8'h5A);
    idle(1);
    check_out("R2", 0, 0, 0);
  endtask

  task automatic t_unprot_abort;
    idle(W);
    do_write(15'h5555, 8'hAA); check_out("R7", 0, 0, 0);
    do_write(15'h0100, 8'h12); check_out("R7", 1, 0, 0);
    check_fwd("R7", 15'h0100, 8'h12);
  endtask

  task automatic t_enable;
    idle(W);
    seq_unlock("R3");
    do_write(15'h0040, 8'h11);
    check_out("R5", 1, 0, 1);
    check_fwd("R5", 15'h0040, 8'h11);
  endtask

  task automatic t_blocked;
    idle(W);
    do_write(15'h0041, 8'h22);
    check_out("R4", 0, 1, 1);
    idle(1);
    check_out("R4", 0, 0, 1);
  endtask

  task automatic t_reset_keeps;
    idle(W);
    @(negedge clk); rst = 1'b1;
    idle(3);
    check("R9", "prot_on in reset", 32'(prot_on), 32'd1);
    rst = 1'b0;
    idle(1);
    check_out("R9", 0, 0, 1);
  endtask

  task automatic t_unlock_window;
    idle(W);
    seq_unlock("R5");
    do_write(15'h0080, 8'h33); check_out("R5", 1, 0, 1);
    idle(W - 2);  // gap of exactly W edges keeps the window
    do_write(15'h0081, 8'h34); check_out("R8", 1, 0, 1);
    check_fwd("R8", 15'h0081, 8'h34);
    idle(W - 1);  // gap of W+1 edges closes it
    do_write(15'h0082, 8'h35); check_out("R5", 0, 1, 1);
  endtask

  task automatic t_prot_abort;
    idle(W);
    do_write(15'h5555, 8'hAA); check_out("R7", 0, 0, 1);
    do_write(15'h1111, 8'h55); check_out("R7", 0, 1, 1);
    do_write(15'h5555, 8'hA0); check_out("R7", 0, 1, 1);
  endtask

  task automatic t_gap_abort;
    idle(W);
    do_write(15'h5555, 8'hAA); check_out("R8", 0, 0, 1);
    idle(W - 1);
    do_write(15'h2AAA, 8'h55); check_out("R8", 0, 1, 1);
    idle(W);
    do_write(15'h5555, 8'hAA); check_out("R8", 0, 0, 1);
    idle(W - 2);
    do_write(15'h2AAA, 8'h55); check_out("R8", 0, 0, 1);
    do_write(15'h5555, 8'hA0); check_out("R8", 0, 0, 1);
    do_write(15'h00C0, 8'h44); check_out("R8", 1, 0, 1);
  endtask

  task automatic t_disable;
    idle(W);
    do_write(15'h5555, 8'hAA); check_out("R6", 0, 0, 1);
    do_write(15'h2AAA, 8'h55); check_out("R6", 0, 0, 1);
    do_write(15'h5555, 8'h80); check_out("R6", 0, 0, 1);
    do_write(15'h5555, 8'hAA); check_out("R6", 0, 0, 1);
    do_write(15'h2AAA, 8'h55); check_out("R6", 0, 0, 1);
    do_write(15'h5555, 8'h20); check_out("R6", 0, 0, 0);
    idle(W);
    do_write(15'h0200, 8'h66); check_out("R6", 1, 0, 0);
    check_fwd("R6", 15'h0200, 8'h66);
  endtask

  task automatic t_por;
    idle(W);
    seq_unlock("R3");
    idle(W);
    @(negedge clk); por_clr = 1'b1;
    @(negedge clk); por_clr = 1'b0;
    check_out("R1", 0, 0, 0);
    do_write(15'h0300, 8'h77); check_out("R9", 1, 0, 0);
  endtask

  initial begin
    rst = 1'b1; por_clr = 1'b1; wr_valid = 1'b0; wr_addr = '0; wr_data = '0;
    idle(3);
    por_clr = 1'b0;
    idle(2);
    rst = 1'b0;
    idle(1);
    t_reset_state();
    t_plain_write();
    t_unprot_abort();
    t_enable();
    t_blocked();
    t_reset_keeps();
    t_unlock_window();
    t_prot_abort();
    t_gap_abort();
    t_disable();
    t_por();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_bad);
      $finish;
    end
  end
endmodule